// File: doc/BRIEF.md
# Power-Up Command Gating Controller

This block sits between a serial flash memory's command decoder and its supply monitors. It decides when commands may be answered while the supply ramps up or collapses. Two synchronous flags come in. One says the supply is above the write-inhibit threshold. The other says the supply is above the operating minimum. From these two flags the block runs two delay counters and produces two registered permissions. One releases read-class commands. The other releases modify-class commands, which are commands that write, program, erase or change protection.

The two permissions come from independent thresholds. Reads open once the operating-minimum delay has run, even if the longer write-inhibit delay is still pending. Modify commands need both delays to have run. The block also does the following:
- holds an internal reset while the supply is low;
- owns the write-enable latch;
- reports a two-bit power state, which reaches standby once everything is released;
- gives each command strobe a verdict.

The verdict is an accept pulse, a reject pulse, or silence when the block is not answering at all.

Top module: `flash_pwr_gate`

## Requirements
- R1: While `vwi_ok_i` is low, `int_rst_o` is high from the next cycle on. A command strobed in any cycle where `vwi_ok_i` is low gives neither `cmd_accept_o` nor `cmd_reject_o`.
- R2: `mod_allow_o` rises only after `vwi_ok_i` has been sampled high on `PUW_CYC` consecutive clock edges. It rises on exactly the edge that completes that run, provided R3 also holds.
- R3: `mod_allow_o` additionally requires the operating-minimum delay of R4 to be complete. A dip on `vmin_ok_i` alone removes it.
- R4: `rd_allow_o` rises on the edge that completes `VSL_CYC` consecutive edges with both `vwi_ok_i` and `vmin_ok_i` high. This does not depend on the `PUW_CYC` delay.
- R5: `pwr_state_o` reads 0 when unpowered, 1 when arming (no permission yet), 2 when only reads are allowed, and 3 in standby (both permissions). `standby_o` is high exactly in state 3. After reset the state is 0, `int_rst_o` is high and `wel_o` is low.
- R6: A low sample on `vwi_ok_i` clears both permissions and `wel_o` on that edge. It also restarts both delays from zero, so even a one-cycle dip re-arms the full waits.
- R7: `cmd_op_i` encodes the operation as follows. 0 is a read, checked against read permission, with no latch effect. 1 sets the write-enable latch and is modify class. 2 is program/erase, which is modify class and clears the latch. 3 clears the latch and is checked against read permission. An accepted command pulses `cmd_accept_o` one cycle after its strobe.
- R8: A command that lacks its class permission, while the other permission is held, pulses `cmd_reject_o` for one cycle. It leaves `wel_o` unchanged. Accept and reject never coincide.
- R9: While neither permission is held, strobes produce no pulse and change no state.
- R10: A strobe with `cs_sel_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vwi_ok_i | input | 1 | Supply above write-inhibit threshold |
| vmin_ok_i | input | 1 | Supply above operating minimum |
| cs_sel_i | input | 1 | Chip selected |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | Operation code (see R7) |
| int_rst_o | output | 1 | Internal reset for downstream logic |
| rd_allow_o | output | 1 | Read-class commands permitted |
| mod_allow_o | output | 1 | Modify-class commands permitted |
| cmd_accept_o | output | 1 | One-cycle accept verdict |
| cmd_reject_o | output | 1 | One-cycle reject verdict |
| wel_o | output | 1 | Write-enable latch |
| pwr_state_o | output | 2 | Power state (see R5) |
| standby_o | output | 1 | Standby, fully accessible |

## Verification
Command judgment can fall in the same cycle as a permission change. The sharpest case is a strobe presented on the very edge where `vwi_ok_i` drops while the latch is set. The bench provokes this deliberately. It also provokes strobes on the edge where `rd_allow_o` or `mod_allow_o` first rises, and on the edge of a `vmin_ok_i`-only dip. A behavioural model judges each case on every clock. It counts consecutive high samples and evaluates the strobe against the permissions that were visible before the edge. The supply drop always wins, so the strobe is silent and the latch clears.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_SETWEL = 2'd1,
        OP_MODIFY = 2'd2,
        OP_CLRWEL = 2'd3
    } pwg_op_e;

    typedef enum logic [1:0] {
        PS_OFF      = 2'd0,
        PS_ARMING   = 2'd1,
        PS_READONLY = 2'd2,
        PS_STANDBY  = 2'd3
    } pwg_pstate_e;

    typedef struct packed {
        logic        rd;
        logic        mod;
        logic        irst;
        pwg_pstate_e st;
    } pwg_perm_t;

    typedef struct packed {
        logic wel;
        logic acc;
        logic rej;
    } pwg_cmd_t;

    function automatic logic op_is_modify(pwg_op_e op);
        return (op == OP_SETWEL) || (op == OP_MODIFY);
    endfunction

endpackage

// File: rtl/pwg_timer.sv
module pwg_timer #(
    parameter int unsigned DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic done_nx_o
);
    localparam int unsigned CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LIM = CW'(DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    // Count consecutive armed samples, saturating at the delay
    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
        done_nx_o = arm_i && (cnt_d == LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pwg_cmd_gate.sv
module pwg_cmd_gate
    import pwg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    vwi_i,
    input  logic    valid_i,
    input  logic    cs_i,
    input  pwg_op_e op_i,
    input  logic    rd_ok_i,
    input  logic    mod_ok_i,
    output logic    wel_o,
    output logic    acc_o,
    output logic    rej_o
);
    pwg_cmd_t d, q;
    logic live, any_ok, need_ok;

    always_comb begin
        d       = q;
        d.acc   = 1'b0;
        d.rej   = 1'b0;
        live    = valid_i && cs_i && vwi_i;
        any_ok  = rd_ok_i || mod_ok_i;
        need_ok = op_is_modify(op_i) ? mod_ok_i : rd_ok_i;
        if (!vwi_i) begin
            d.wel = 1'b0;
        end else if (live && any_ok) begin
            if (need_ok) begin
                d.acc = 1'b1;
                unique case (op_i)
                    OP_SETWEL: d.wel = 1'b1;
                    OP_MODIFY: d.wel = 1'b0;
                    OP_CLRWEL: d.wel = 1'b0;
                    default:   d.wel = q.wel;
                endcase
            end else begin
                d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wel_o = q.wel;
    assign acc_o = q.acc;
    assign rej_o = q.rej;
endmodule

// File: rtl/flash_pwr_gate.sv
module flash_pwr_gate
    import pwg_pkg::*;
#(
    parameter int unsigned PUW_CYC = 40,
    parameter int unsigned VSL_CYC = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vwi_ok_i,
    input  logic       vmin_ok_i,
    input  logic       cs_sel_i,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_op_i,
    output logic       int_rst_o,
    output logic       rd_allow_o,
    output logic       mod_allow_o,
    output logic       cmd_accept_o,
    output logic       cmd_reject_o,
    output logic       wel_o,
    output logic [1:0] pwr_state_o,
    output logic       standby_o
);
    logic puw_nx, vsl_nx;
    pwg_perm_t d, q;

    pwg_timer #(.DELAY(PUW_CYC)) u_puw_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (vwi_ok_i),
        .done_nx_o (puw_nx)
    );

    pwg_timer #(.DELAY(VSL_CYC)) u_vsl_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (vwi_ok_i && vmin_ok_i),
        .done_nx_o (vsl_nx)
    );

    always_comb begin
        d.rd   = vsl_nx;
        d.mod  = vsl_nx && puw_nx;
        d.irst = !vwi_ok_i;
        if (!vwi_ok_i) begin
            d.st = PS_OFF;
        end else if (!d.rd) begin
            d.st = PS_ARMING;
        end else if (!d.mod) begin
            d.st = PS_READONLY;
        end else begin
            d.st = PS_STANDBY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{rd: 1'b0, mod: 1'b0, irst: 1'b1, st: PS_OFF};
        end else begin
            q <= d;
        end
    end

    pwg_cmd_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .vwi_i    (vwi_ok_i),
        .valid_i  (cmd_valid_i),
        .cs_i     (cs_sel_i),
        .op_i     (pwg_op_e'(cmd_op_i)),
        .rd_ok_i  (q.rd),
        .mod_ok_i (q.mod),
        .wel_o    (wel_o),
        .acc_o    (cmd_accept_o),
        .rej_o    (cmd_reject_o)
    );

    assign int_rst_o   = q.irst;
    assign rd_allow_o  = q.rd;
    assign mod_allow_o = q.mod;
    assign pwr_state_o = q.st;
    assign standby_o   = (q.st == PS_STANDBY);
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
    parameter int unsigned PUW_CYC = 40,
    parameter int unsigned VSL_CYC = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vwi_ok_i,
    input logic       vmin_ok_i,
    input logic       cs_sel_i,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_op_i,
    input logic       int_rst_o,
    input logic       rd_allow_o,
    input logic       mod_allow_o,
    input logic       cmd_accept_o,
    input logic       cmd_reject_o,
    input logic       wel_o,
    input logic [1:0] pwr_state_o,
    input logic       standby_o
);
    int unsigned puw_seen, vsl_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            puw_seen <= 0;
            vsl_seen <= 0;
        end else begin
            puw_seen <= !vwi_ok_i ? 0 : (puw_seen < PUW_CYC ? puw_seen + 1 : puw_seen);
            vsl_seen <= !(vwi_ok_i && vmin_ok_i) ? 0 :
                        (vsl_seen < VSL_CYC ? vsl_seen + 1 : vsl_seen);
        end
    end

    AST_UNPOWERED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !vwi_ok_i |=> (!cmd_accept_o && !cmd_reject_o && int_rst_o)); // R1
    AST_MOD_AFTER_PUW: assert property (@(posedge clk) disable iff (!rst_n)
        mod_allow_o |-> (puw_seen >= PUW_CYC)); // R2
    AST_MOD_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mod_allow_o |-> rd_allow_o); // R3
    AST_RD_AFTER_VSL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_allow_o |-> (vsl_seen >= VSL_CYC)); // R4
    AST_STANDBY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (mod_allow_o && !int_rst_o && pwr_state_o == 2'd3)); // R5
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !vwi_ok_i |=> (!rd_allow_o && !mod_allow_o && !wel_o)); // R6
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept_o && cmd_reject_o)); // R8
    AST_REJECT_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject_o |-> $stable(wel_o)); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_allow_o && !mod_allow_o) |=> (!cmd_accept_o && !cmd_reject_o)); // R9
    AST_CS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_sel_i || !cmd_valid_i) |=> (!cmd_accept_o && !cmd_reject_o)); // R10
endmodule

bind flash_pwr_gate pwg_checker #(.PUW_CYC(PUW_CYC), .VSL_CYC(VSL_CYC)) u_pwg_chk (.*);

// File: tb/flash_pwr_gate_bench.sv
module flash_pwr_gate_bench;
    localparam int PUW = 40;
    localparam int VSL = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vwi = 1'b0, vmin = 1'b0, cs = 1'b0, vld = 1'b0;
    logic [1:0] op = 2'd0;
    logic       irst, rd_al, mod_al, acc, rej, wel, sby;
    logic [1:0] pst;

    int checks = 0, fails = 0, cyc = 0;
    string phase = "R5";

    // behavioural reference state
    int  m_puw = 0, m_vsl = 0;
    bit  m_rd = 0, m_mod = 0, m_irst = 1, m_wel = 0, m_acc = 0, m_rej = 0;
    int  m_st = 0;

    flash_pwr_gate #(.PUW_CYC(PUW), .VSL_CYC(VSL)) u_flash_pwr_gate (
        .clk(clk), .rst_n(rst_n), .vwi_ok_i(vwi), .vmin_ok_i(vmin),
        .cs_sel_i(cs), .cmd_valid_i(vld), .cmd_op_i(op),
        .int_rst_o(irst), .rd_allow_o(rd_al), .mod_allow_o(mod_al),
        .cmd_accept_o(acc), .cmd_reject_o(rej), .wel_o(wel),
        .pwr_state_o(pst), .standby_o(sby)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        bit old_rd, old_mod, need;
        cyc++;
        if (!rst_n) begin
            m_puw = 0; m_vsl = 0; m_rd = 0; m_mod = 0; m_irst = 1;
            m_wel = 0; m_acc = 0; m_rej = 0; m_st = 0;
        end else begin
            old_rd  = m_rd;
            old_mod = m_mod;
            m_puw = vwi ? m_puw + 1 : 0;
            m_vsl = (vwi && vmin) ? m_vsl + 1 : 0;
            m_rd  = (m_vsl >= VSL);
            m_mod = m_rd && (m_puw >= PUW);
            m_acc = 0;
            m_rej = 0;
            if (!vwi) begin
                m_wel = 0;
            end else if (vld && cs && (old_rd || old_mod)) begin
                need = (op == 2'd1 || op == 2'd2) ? old_mod : old_rd;
                if (need) begin
                    m_acc = 1;
                    if (op == 2'd1) m_wel = 1;
                    else if (op != 2'd0) m_wel = 0;
                end else begin
                    m_rej = 1;
                end
            end
            m_irst = !vwi;
            m_st = !vwi ? 0 : (!m_rd ? 1 : (!m_mod ? 2 : 3));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("R1 int_rst", irst, m_irst);
        chk("R4 rd_allow", rd_al, m_rd);
        chk("R2 R3 mod_allow", mod_al, m_mod);
        chk("R7 accept", acc, m_acc);
        chk("R8 reject", rej, m_rej);
        chk("R7 wel", wel, m_wel);
        chk("R5 state", pst, m_st);
        chk("R5 standby", sby, m_st == 3);
    end

    task automatic drive(bit v_wi, bit v_min, bit c, bit v, int o, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
            vwi = v_wi; vmin = v_min; cs = c; vld = v; op = 2'(o);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        drive(0, 0, 0, 0, 0, 4);
        @(negedge clk);
        phase = "R5";
        chk("R5 reset state", pst, 0);
        chk("R5 reset int_rst", irst, 1);
        chk("R5 reset wel", wel, 0);
        @(posedge clk); #5; rst_n = 1;
        phase = "R1";
        for (int k = 0; k < 8; k++) drive(0, 1, 1, 1, k % 4, 1);
        phase = "R9";
        for (int k = 0; k < 8; k++) drive(1, 0, 1, 1, k % 4, 1);
        phase = "R4";
        drive(1, 1, 0, 0, 0, 1);
        for (int k = 0; k < 20; k++) drive(1, 1, 1, 1, (k % 2) ? 1 : 0, 1);
        phase = "R2";
        for (int k = 0; k < 20; k++) drive(1, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R2 modify open", mod_al, 1);
        phase = "R7";
        drive(1, 1, 1, 1, 1, 1); drive(1, 1, 1, 1, 0, 1);
        drive(1, 1, 1, 1, 2, 1); drive(1, 1, 1, 1, 1, 1);
        drive(1, 1, 1, 1, 3, 1); drive(1, 1, 1, 1, 1, 1);
        drive(1, 1, 0, 0, 0, 2);
        @(negedge clk);
        chk("R7 latch set", wel, 1);
        phase = "R10";
        drive(1, 1, 0, 1, 3, 3);
        drive(1, 1, 0, 0, 0, 1);
        @(negedge clk);
        chk("R10 latch kept", wel, 1);
        phase = "R6";
        drive(0, 1, 1, 1, 0, 1);
        drive(1, 1, 1, 1, 0, 1);
        @(negedge clk);
        chk("R6 latch cleared by dip", wel, 0);
        chk("R6 modify closed by dip", mod_al, 0);
        for (int k = 0; k < 50; k++) drive(1, 1, 1, 1, (k % 3 == 0) ? 1 : 0, 1);
        phase = "R3";
        drive(1, 0, 1, 1, 1, 1);
        for (int k = 0; k < 16; k++) drive(1, 1, 1, 1, 1, 1);
        phase = "R8";
        drive(1, 0, 0, 0, 0, 1);
        for (int k = 0; k < 14; k++) drive(1, 1, 1, 1, 2, 1);
        phase = "R1";
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom % 100;
            drive(r > 2, r > 6, ($urandom % 4) != 0, ($urandom % 2) == 1, $urandom % 4, 1);
        end
        drive(1, 1, 0, 0, 0, 3);
        finish_run();
    end
endmodule